// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a single memory access may proceed under a table of protection entries. Each entry arrives already decoded as a half-open byte range `[lo, hi)`, a 2-bit matching mode, read/write/execute permission bits and a lock bit. A separate register block builds these ranges. The checker receives a physical address, a power-of-two access size, an access type and a flag that says whether the requester runs in machine mode. It returns an allow/fault decision, a fault cause code and a flag that says whether the table had to be consulted at all.

The per-entry comparisons and the lowest-index selection are combinational. The decision is captured in one register stage, so the outputs follow the request by exactly one clock. A pipeline stage feeding a fault or commit point places the request on the inputs in one cycle and reads the verdict in the next.

Top module: `pmpChecker`

## Requirements
- R1: An entry matches only when both the first byte (`reqAddr`) and the last byte (`reqAddr + 2^reqSize - 1`) satisfy `lo <= byte < hi` for that entry. An access that straddles a range boundary does not match that entry.
- R2: When several entries match, the one with the lowest index decides, whatever its permissions.
- R3: An entry with mode 0 (off) never matches, even if its range covers the access. Modes 1 to 3 all enable matching.
- R4: In machine mode (`reqMachine`=1), when the check is needed and the deciding entry has lock=0, the access is allowed whatever its permission bits.
- R5: Otherwise, the deciding entry's permission field allows the access by type. `entryPerm` bit 0 grants read (type 0), bit 1 grants write (type 1), and bit 2 grants execute (types 2 and 3). A missing permission faults, and a locked entry binds machine mode too.
- R6: When the check is needed and no entry matches, a machine-mode access is allowed and any lower-privilege access faults.
- R7: When every entry has mode 0, the access is allowed and `chkNeeded` is 0.
- R8: In machine mode with no lock bit set in any entry, the access is allowed and `chkNeeded` is 0. In all other cases `chkNeeded` is 1.
- R9: `faultValid` is the inverse of `accAllow`. A fault carries cause 5 for a read, 7 for a write and 1 for an execute. `faultCause` is 0 when the access is allowed.
- R10: Outputs are registered and reflect the inputs present at the previous rising clock edge. While `rstN` is low, all four outputs are 0.
- R11: `reqSize` gives log2 of the byte count (0..3 means 1, 2, 4 or 8 bytes). A span whose last byte lies beyond the top of the address space matches no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqAddr | input | AW | Physical address of the first byte |
| reqSize | input | SZW | log2 of access size in bytes |
| reqType | input | 2 | 0 read, 1 write, 2 or 3 execute |
| reqMachine | input | 1 | 1 when the requester runs in machine mode |
| entryLo | input | N*AW | Inclusive lower bound for each entry, entry i at bits i*AW |
| entryHi | input | N*AW | Exclusive upper bound for each entry |
| entryMode | input | N*2 | Matching mode for each entry, 0 means off |
| entryPerm | input | N*3 | Permissions for each entry: bit 0 read, bit 1 write, bit 2 execute |
| entryLock | input | N | Lock bit for each entry |
| accAllow | output | 1 | Access allowed |
| faultValid | output | 1 | Access faults |
| faultCause | output | 4 | Cause code of the fault, 0 when allowed |
| chkNeeded | output | 1 | The table was consulted rather than bypassed |

## Verification
Directed patterns first place one enabled entry and probe it with each access type from both privilege levels. This separates the permission path from the machine-mode bypass and from the lock override. Spans placed exactly at range edges, including one that runs off the top of the address space, separate the two-ended containment test from a first-byte-only test. Stacked entries, some disabled, with conflicting permissions show whether the lowest enabled index wins rather than the highest. A final run of random small tables with overlapping ranges compares every output against a behavioural scan in every cycle.

// File: rtl/pmpChkPkg.sv
`timescale 1ns/1ps
package pmpChkPkg;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } matchMode_e;

  typedef enum logic [1:0] {
    ACC_READ     = 2'd0,
    ACC_WRITE    = 2'd1,
    ACC_EXEC     = 2'd2,
    ACC_EXEC_ALT = 2'd3
  } accType_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  localparam logic [3:0] CAUSE_NONE  = 4'd0;
  localparam logic [3:0] CAUSE_INSTR = 4'd1;
  localparam logic [3:0] CAUSE_LOAD  = 4'd5;
  localparam logic [3:0] CAUSE_STORE = 4'd7;

  // Strobes handed from the datapath to the decision control
  typedef struct packed {
    logic       hit;
    logic [2:0] perm;
    logic       lock;
    logic       anyActive;
    logic       anyLock;
  } hitInfo_t;

endpackage

// File: rtl/pmpChkPrio.sv
`timescale 1ns/1ps
module pmpChkPrio #(
  parameter int N = 16
) (
  input  logic [N-1:0] reqVec,
  output logic [N-1:0] grantVec,
  output logic         anyHit
);
  // Isolate the lowest set bit: two's complement carry stops at it
  assign grantVec = reqVec & (~reqVec + N'(1));
  assign anyHit   = |reqVec;
endmodule

// File: rtl/pmpChkDatapath.sv
`timescale 1ns/1ps
module pmpChkDatapath
  import pmpChkPkg::*;
#(
  parameter int N   = 16,
  parameter int AW  = 32,
  parameter int SZW = 2
) (
  input  logic [AW-1:0]   reqAddr,
  input  logic [SZW-1:0]  reqSize,
  input  logic [N*AW-1:0] entryLo,
  input  logic [N*AW-1:0] entryHi,
  input  logic [N*2-1:0]  entryMode,
  input  logic [N*3-1:0]  entryPerm,
  input  logic [N-1:0]    entryLock,
  output hitInfo_t        info
);
  localparam int SPAN_W = AW + 1;

  logic [SPAN_W-1:0] lastAddr;
  logic [N-1:0]      matchVec;
  logic [N-1:0]      activeVec;
  logic [N-1:0]      grantVec;
  logic              anyHit;
  logic [2:0]        selPerm;
  logic              selLock;

  // One extra bit keeps a span that runs off the top from wrapping
  assign lastAddr = {1'b0, reqAddr} + (SPAN_W'(1) << reqSize) - SPAN_W'(1);

  for (genvar g = 0; g < N; g++) begin : gEntry
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
    logic          enabled;
    assign lo      = entryLo[g*AW +: AW];
    assign hi      = entryHi[g*AW +: AW];
    assign enabled = (entryMode[g*2 +: 2] != MATCH_OFF);
    assign activeVec[g] = enabled;
    assign matchVec[g]  = enabled && (reqAddr >= lo) && (lastAddr < {1'b0, hi});
  end

  pmpChkPrio #(.N(N)) u_prio (
    .reqVec  (matchVec),
    .grantVec(grantVec),
    .anyHit  (anyHit)
  );

  // One-hot grant turns selection into an AND-OR tree
  always_comb begin
    selPerm = '0;
    selLock = 1'b0;
    for (int i = 0; i < N; i++) begin
      selPerm = selPerm | ({3{grantVec[i]}} & entryPerm[i*3 +: 3]);
      selLock = selLock | (grantVec[i] & entryLock[i]);
    end
  end

  always_comb begin
    info.hit       = anyHit;
    info.perm      = selPerm;
    info.lock      = selLock;
    info.anyActive = |activeVec;
    info.anyLock   = |entryLock;
  end
endmodule

// File: rtl/pmpChkControl.sv
`timescale 1ns/1ps
module pmpChkControl
  import pmpChkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  hitInfo_t   info,
  input  logic [1:0] reqType,
  input  logic       reqMachine,
  output logic       accAllow,
  output logic       faultValid,
  output logic [3:0] faultCause,
  output logic       chkNeeded
);
  logic       bypass;
  logic       permOk;
  logic       allowNext;
  logic [3:0] causeNext;

  assign bypass = !info.anyActive || (reqMachine && !info.anyLock);

  always_comb begin
    unique case (reqType)
      ACC_READ:  permOk = info.perm[PERM_R];
      ACC_WRITE: permOk = info.perm[PERM_W];
      default:   permOk = info.perm[PERM_X];
    endcase
  end

  always_comb begin
    if (bypass)                            allowNext = 1'b1;
    else if (!info.hit)                    allowNext = reqMachine;
    else if (reqMachine && !info.lock)     allowNext = 1'b1;
    else                                   allowNext = permOk;
  end

  always_comb begin
    if (allowNext)                 causeNext = CAUSE_NONE;
    else if (reqType == ACC_READ)  causeNext = CAUSE_LOAD;
    else if (reqType == ACC_WRITE) causeNext = CAUSE_STORE;
    else                           causeNext = CAUSE_INSTR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accAllow   <= 1'b0;
      faultValid <= 1'b0;
      faultCause <= CAUSE_NONE;
      chkNeeded  <= 1'b0;
    end else begin
      accAllow   <= allowNext;
      faultValid <= !allowNext;
      faultCause <= causeNext;
      chkNeeded  <= !bypass;
    end
  end
endmodule

// File: rtl/pmpChecker.sv
`timescale 1ns/1ps
module pmpChecker
  import pmpChkPkg::*;
#(
  parameter int N   = 16,
  parameter int AW  = 32,
  parameter int SZW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   reqAddr,
  input  logic [SZW-1:0]  reqSize,
  input  logic [1:0]      reqType,
  input  logic            reqMachine,
  input  logic [N*AW-1:0] entryLo,
  input  logic [N*AW-1:0] entryHi,
  input  logic [N*2-1:0]  entryMode,
  input  logic [N*3-1:0]  entryPerm,
  input  logic [N-1:0]    entryLock,
  output logic            accAllow,
  output logic            faultValid,
  output logic [3:0]      faultCause,
  output logic            chkNeeded
);
  hitInfo_t info;

  pmpChkDatapath #(.N(N), .AW(AW), .SZW(SZW)) u_dp (
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .entryLo  (entryLo),
    .entryHi  (entryHi),
    .entryMode(entryMode),
    .entryPerm(entryPerm),
    .entryLock(entryLock),
    .info     (info)
  );

  pmpChkControl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .info      (info),
    .reqType   (reqType),
    .reqMachine(reqMachine),
    .accAllow  (accAllow),
    .faultValid(faultValid),
    .faultCause(faultCause),
    .chkNeeded (chkNeeded)
  );
endmodule

// File: rtl/pmpChecker_sva.sv
`timescale 1ns/1ps
module pmpChecker_sva
  import pmpChkPkg::*;
#(
  parameter int N = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic [1:0]     reqType,
  input logic           reqMachine,
  input logic [N*2-1:0] entryMode,
  input logic [N-1:0]   entryLock,
  input logic           accAllow,
  input logic           faultValid,
  input logic [3:0]     faultCause,
  input logic           chkNeeded
);
  logic anyOn;
  always_comb begin
    anyOn = 1'b0;
    for (int i = 0; i < N; i++) anyOn = anyOn | (entryMode[i*2 +: 2] != 2'd0);
  end

  AST_FAULT_INVERSE: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (faultValid != accAllow)); // R9

  AST_ALLOW_NO_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    accAllow |-> (faultCause == CAUSE_NONE)); // R9

  AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && faultValid && $past(reqType) == ACC_READ) |-> (faultCause == CAUSE_LOAD)); // R9

  AST_CAUSE_STORE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && faultValid && $past(reqType) == ACC_WRITE) |-> (faultCause == CAUSE_STORE)); // R9

  AST_CAUSE_INSTR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && faultValid && $past(reqType[1])) |-> (faultCause == CAUSE_INSTR)); // R9

  AST_ALL_OFF_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(anyOn)) |-> (accAllow && !chkNeeded)); // R7

  AST_MACHINE_UNLOCKED_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(reqMachine) && $past(entryLock) == '0) |-> (accAllow && !chkNeeded)); // R8

  AST_SKIP_MEANS_ALLOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !chkNeeded) |-> accAllow); // R7
endmodule

bind pmpChecker pmpChecker_sva #(.N(N)) u_sva (.*);

// File: tb/pmpChecker_bench.sv
`timescale 1ns/1ps
module pmpChecker_bench;
  localparam int N   = 16;
  localparam int AW  = 32;
  localparam int SZW = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [AW-1:0]   reqAddr = '0;
  logic [SZW-1:0]  reqSize = '0;
  logic [1:0]      reqType = '0;
  logic            reqMachine = 1'b0;
  logic [N*AW-1:0] entryLo;
  logic [N*AW-1:0] entryHi;
  logic [N*2-1:0]  entryMode;
  logic [N*3-1:0]  entryPerm;
  logic [N-1:0]    entryLock;
  logic            accAllow;
  logic            faultValid;
  logic [3:0]      faultCause;
  logic            chkNeeded;

  logic [AW-1:0] eLo   [N];
  logic [AW-1:0] eHi   [N];
  logic [1:0]    eMode [N];
  logic [2:0]    ePerm [N];
  logic          eLock [N];

  int totalCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      entryLo[i*AW +: AW] = eLo[i];
      entryHi[i*AW +: AW] = eHi[i];
      entryMode[i*2 +: 2] = eMode[i];
      entryPerm[i*3 +: 3] = ePerm[i];
      entryLock[i]        = eLock[i];
    end
  end

  pmpChecker #(.N(N), .AW(AW), .SZW(SZW)) u_pmpChecker (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqType(reqType), .reqMachine(reqMachine), .entryLo(entryLo),
    .entryHi(entryHi), .entryMode(entryMode), .entryPerm(entryPerm),
    .entryLock(entryLock), .accAllow(accAllow), .faultValid(faultValid),
    .faultCause(faultCause), .chkNeeded(chkNeeded)
  );

  // Behavioural scan of the table, written from the requirements
  function automatic void refModel(output logic allowE, output logic [3:0] causeE,
                                   output logic needE);
    longint first = longint'(reqAddr);
    longint last  = first + (longint'(1) << reqSize) - 1;
    int active = 0;
    bit lockAny = 0;
    int hit = -1;
    for (int i = 0; i < N; i++) begin
      if (eMode[i] != 0) active++;
      if (eLock[i]) lockAny = 1;
    end
    for (int i = 0; i < N; i++)
      if (hit < 0 && eMode[i] != 0 && first >= longint'(eLo[i]) && last < longint'(eHi[i]))
        hit = i;
    needE = !(active == 0 || (reqMachine && !lockAny));
    if (!needE) allowE = 1'b1;
    else if (hit < 0) allowE = reqMachine;
    else if (reqMachine && !eLock[hit]) allowE = 1'b1;
    else if (reqType == 2'd0) allowE = ePerm[hit][0];
    else if (reqType == 2'd1) allowE = ePerm[hit][1];
    else allowE = ePerm[hit][2];
    if (allowE) causeE = 4'd0;
    else if (reqType == 2'd0) causeE = 4'd5;
    else if (reqType == 2'd1) causeE = 4'd7;
    else causeE = 4'd1;
  endfunction

  task automatic checkOut(string tag, logic aE, logic fE, logic [3:0] cE, logic nE);
    totalCnt++;
    if (accAllow !== aE || faultValid !== fE || faultCause !== cE || chkNeeded !== nE) begin
      failCnt++;
      $display("FAIL %s: allow=%0b fault=%0b cause=%0d need=%0b, expected allow=%0b fault=%0b cause=%0d need=%0b",
               tag, accAllow, faultValid, faultCause, chkNeeded, aE, fE, cE, nE);
    end
  endtask

  // Inputs are set at a falling edge; compare at the next falling edge
  task automatic step(string tag);
    logic aE, nE;
    logic [3:0] cE;
    refModel(aE, cE, nE);
    @(negedge clk);
    checkOut(tag, aE, !aE, cE, nE);
  endtask

  task automatic req(logic [AW-1:0] a, int sz, int ty, logic m, string tag);
    reqAddr = a; reqSize = SZW'(sz); reqType = 2'(ty); reqMachine = m;
    step(tag);
  endtask

  task automatic setEntry(int i, logic [AW-1:0] lo, logic [AW-1:0] hi, int md, int pm, logic lk);
    eLo[i] = lo; eHi[i] = hi; eMode[i] = 2'(md); ePerm[i] = 3'(pm); eLock[i] = lk;
  endtask

  task automatic clearTable();
    for (int i = 0; i < N; i++) setEntry(i, '0, '0, 0, 0, 1'b0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    totalCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    clearTable();
    setEntry(0, 32'h0, 32'hFFFF_FFFF, 1, 7, 1'b0);
    reqType = 2'd1;
    repeat (3) @(negedge clk);
    checkOut("R10 reset", 1'b0, 1'b0, 4'd0, 1'b0);
    clearTable();
    rstN = 1'b1;

    // R7: all entries off
    req(32'h1234, 0, 0, 1'b0, "R7 all off user read");
    req(32'h1234, 3, 1, 1'b0, "R7 all off user write");

    // Single TOR-like entry with read only
    setEntry(3, 32'h1000, 32'h2000, 1, 3'b001, 1'b0);
    req(32'h1000, 2, 0, 1'b0, "R5 read granted");
    req(32'h1000, 2, 1, 1'b0, "R5 R9 write denied");
    // R10: output still reflects the previous request before the edge
    reqType = 2'd2;
    #1;
    checkOut("R10 registered hold", 1'b0, 1'b1, 4'd7, 1'b1);
    step("R5 R9 exec denied");
    req(32'h1800, 0, 3, 1'b0, "R5 type 3 treated as execute");
    req(32'h1000, 2, 1, 1'b1, "R8 machine no lock bypass");

    // R1: span edges
    req(32'h1FFE, 2, 0, 1'b0, "R1 span crosses top");
    req(32'h1FFC, 2, 0, 1'b0, "R1 span ends at last byte");
    req(32'h0FFF, 1, 0, 1'b0, "R1 span starts below");

    // R2, R3: lower locked entry with no permission wins; an off entry is skipped
    setEntry(0, 32'h1000, 32'h2000, 0, 3'b111, 1'b1);
    setEntry(1, 32'h1800, 32'h1900, 2, 3'b000, 1'b1);
    req(32'h1800, 0, 0, 1'b0, "R2 R3 lowest enabled entry decides");
    req(32'h1900, 0, 0, 1'b0, "R2 falls through to entry 3");
    req(32'h1800, 0, 0, 1'b1, "R5 locked entry binds machine");
    req(32'h1000, 0, 1, 1'b1, "R4 machine unlocked entry ignores perms");
    req(32'h9000, 0, 2, 1'b1, "R6 miss machine allowed");
    req(32'h9000, 0, 2, 1'b0, "R6 miss user faults");

    // R3: enabling entry 0 changes the decision
    eMode[0] = 2'd3;
    req(32'h1800, 0, 0, 1'b0, "R3 entry 0 enabled now decides");

    // R11: span running past the top of the address space
    clearTable();
    setEntry(2, 32'hFFFF_0000, 32'hFFFF_FFFF, 1, 3'b111, 1'b0);
    req(32'hFFFF_FFF0, 3, 0, 1'b0, "R11 span inside high range");
    req(32'hFFFF_FFFC, 3, 0, 1'b0, "R11 span wraps past top");
    req(32'hFFFF_FFFE, 0, 1, 1'b0, "R11 single byte below bound");

    // Random tables with overlap
    for (int k = 0; k < 400; k++) begin
      for (int j = 0; j < 3; j++) begin
        int idx = int'($urandom_range(N - 1));
        logic [AW-1:0] lo = AW'($urandom_range(32'h3FF));
        setEntry(idx, lo, lo + AW'($urandom_range(32'h100)), int'($urandom_range(3)),
                 int'($urandom_range(7)), ($urandom_range(7) == 0));
      end
      req(AW'($urandom_range(32'h3FF)), int'($urandom_range(3)), int'($urandom_range(3)),
          1'($urandom_range(1)), "R2 random table");
    end

    summary();
    $finish;
  end
endmodule